// File: doc/BRIEF.md
# Read-Side Routing Fabric for a Multi-Port Register Bus

This block carries read traffic between NM requesting ports and NS target ports of an AXI4-Lite style register bus. Only the read-address and read-data channels are covered. Every external channel passes through a two-entry buffer. A read-address beat accepted from a requester can move toward its target on the clock edge after its handshake. The target index is computed from the top bits of the address.

Addresses that fall in a hole of the map, or that point at a target whose read-enable bit is cleared, go to the last target. That target is the designated error responder. The fabric itself never creates a response code: whatever the error responder returns is passed through unchanged.

Ordering is kept without any transaction identifiers. Each requester port and each target port owns a small route queue. When a request moves from a requester buffer into a target buffer, the requester's queue records the target index and the target's queue records the requester index. A read response is forwarded only when both queue heads agree. When it is forwarded, both entries are removed. Targets must therefore answer in request order.

Top module: `xbr_rd_route`

## Requirements
- R1: After reset every requester `m_arready` bit is 1, and every `m_rvalid` and `s_arvalid` bit is 0.
- R2: With sel = the top SELW address bits, a request goes to target sel when sel < NS-1 and RD_EN[sel] is 1. Any other sel, which is a hole in the map, goes to target NS-1.
- R3: A target whose RD_EN bit is 0 never asserts `s_arvalid`. Addresses that select it are delivered to target NS-1 instead.
- R4: On an idle path, a request accepted at edge k is presented at its target so that the target can accept it at edge k+2. A response accepted from a target at edge q is likewise presented to its requester so that the requester can accept it at edge q+2.
- R5: When several requesters first present requests to the same target on the same edge, the lowest requester index is forwarded first.
- R6: While a target does not accept, its `s_arvalid` stays 1 and `s_araddr` is held. Waiting requests are retried and arrive later in issue order, with none lost.
- R7: Each route queue holds RI_DEPTH entries (default 8). If responses are withheld, a target receives at most 8 requests. A requester accepts at most 8 + RQ_DEPTH (10) requests before `m_arready` drops.
- R8: Each response reaches the requester that issued the matching request, with data and response code unchanged. The error code 2'b11 returned by the error target passes through untouched.
- R9: A requester receives responses in the order of its requests, even when a later target answers before an earlier one.
- R10: While `m_rready` is 0, the presented response stays valid and stable, and it is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_arvalid | input | NM | Read-address valid, per requester |
| m_araddr | input | NM*AW | Read address, per requester |
| m_arready | output | NM | Read-address ready, per requester |
| m_rvalid | output | NM | Read-data valid, per requester |
| m_rdata | output | NM*DW | Read data, per requester |
| m_rresp | output | NM*2 | Read response code, per requester |
| m_rready | input | NM | Read-data ready, per requester |
| s_arvalid | output | NS | Read-address valid, per target |
| s_araddr | output | NS*AW | Read address, per target |
| s_arready | input | NS | Read-address ready, per target |
| s_rvalid | input | NS | Read-data valid, per target |
| s_rdata | input | NS*DW | Read data, per target |
| s_rresp | input | NS*2 | Read response code, per target |
| s_rready | output | NS | Read-data ready, per target |

## Verification
All eight select values are swept from both requesters at once. This separates correct decoding, hole redirection and the masked target from one another, and it confirms that each response returns to its own requester. Two requesters that hit one target on the same edge expose the priority order. Withheld target readiness and withheld responses show that requests wait in place and that route-queue depth limits how many requests are outstanding. A read to a slow target followed by one to a fast target shows that ordering is enforced. Cycle stamps taken at both edges of the fabric pin down the two-edge latency in each direction.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  localparam int RESP_W = 2;
  typedef logic [RESP_W-1:0] rcode_t;
  localparam rcode_t RC_OKAY   = 2'b00;
  localparam rcode_t RC_DECERR = 2'b11;
endpackage

// File: rtl/xbr_fifo.sv
module xbr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         not_full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign not_empty = (cnt != '0);
  assign not_full  = (cnt != FULL_CNT);
  assign do_push   = push && not_full;
  assign do_pop    = pop && not_empty;
  assign dout      = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/xbr_prio.sv
module xbr_prio #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int k = 0; k < N; k++) begin
      if (req[k] && !taken) begin
        gnt[k] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbr_rd_route.sv
module xbr_rd_route
  import xbr_pkg::*;
#(
  parameter int          NM       = 2,
  parameter int          NS       = 4,
  parameter int          AW       = 8,
  parameter int          DW       = 16,
  parameter int          SELW     = 3,
  parameter logic [NS-1:0] RD_EN  = '1,
  parameter int          RQ_DEPTH = 2,
  parameter int          RI_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NM-1:0]      m_arvalid,
  input  logic [NM*AW-1:0]   m_araddr,
  output logic [NM-1:0]      m_arready,
  output logic [NM-1:0]      m_rvalid,
  output logic [NM*DW-1:0]   m_rdata,
  output logic [NM*2-1:0]    m_rresp,
  input  logic [NM-1:0]      m_rready,
  output logic [NS-1:0]      s_arvalid,
  output logic [NS*AW-1:0]   s_araddr,
  input  logic [NS-1:0]      s_arready,
  input  logic [NS-1:0]      s_rvalid,
  input  logic [NS*DW-1:0]   s_rdata,
  input  logic [NS*2-1:0]    s_rresp,
  output logic [NS-1:0]      s_rready
);
  localparam int MIW   = (NM > 1) ? $clog2(NM) : 1;
  localparam int SIW   = (NS > 1) ? $clog2(NS) : 1;
  localparam int ERR_T = NS - 1;
  localparam int RW    = DW + RESP_W;

  function automatic logic [SIW-1:0] pick_target(input logic [AW-1:0] a);
    logic [SELW-1:0] sel;
    sel = a[AW-1 -: SELW];
    pick_target = SIW'(ERR_T);
    for (int k = 0; k < ERR_T; k++)
      if (sel == SELW'(k) && RD_EN[k]) pick_target = SIW'(k);
  endfunction

  // requester side
  logic [AW-1:0]  rq_addr  [NM];
  logic [NM-1:0]  rq_ne, rq_pop;
  logic [SIW-1:0] rq_tgt   [NM];
  logic [SIW-1:0] ri_head  [NM];
  logic [NM-1:0]  ri_ne, ri_nf;
  logic [NM-1:0]  rsp_go;
  logic [RW-1:0]  rsp_din  [NM];
  logic [NM-1:0]  rd_nf;

  // target side
  logic [NM-1:0]  ar_req   [NS];
  logic [NM-1:0]  ar_gnt   [NS];
  logic [NS-1:0]  tg_push, tg_nf, to_ne, to_nf, tg_done, rs_ne;
  logic [AW-1:0]  tg_addr  [NS];
  logic [MIW-1:0] tg_src   [NS];
  logic [MIW-1:0] to_head  [NS];
  logic [RW-1:0]  rs_dout  [NS];

  always_comb begin
    for (int j = 0; j < NS; j++)
      for (int i = 0; i < NM; i++)
        ar_req[j][i] = rq_ne[i] && (rq_tgt[i] == SIW'(j)) && ri_nf[i]
                       && tg_nf[j] && to_nf[j];
  end

  always_comb begin
    rq_pop = '0;
    for (int j = 0; j < NS; j++) begin
      tg_push[j] = 1'b0;
      tg_addr[j] = '0;
      tg_src[j]  = '0;
      for (int i = 0; i < NM; i++) begin
        if (ar_gnt[j][i]) begin
          tg_push[j] = 1'b1;
          tg_addr[j] = rq_addr[i];
          tg_src[j]  = MIW'(i);
          rq_pop[i]  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    rsp_go  = '0;
    tg_done = '0;
    for (int i = 0; i < NM; i++) rsp_din[i] = '0;
    for (int j = 0; j < NS; j++) begin
      for (int i = 0; i < NM; i++) begin
        if (rs_ne[j] && to_ne[j] && to_head[j] == MIW'(i) &&
            ri_ne[i] && ri_head[i] == SIW'(j) && rd_nf[i]) begin
          rsp_go[i]  = 1'b1;
          rsp_din[i] = rs_dout[j];
          tg_done[j] = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_req
    logic [RW-1:0] rd_dout;

    xbr_fifo #(.W(AW), .DEPTH(RQ_DEPTH)) u_arq (
      .clk, .rst, .push(m_arvalid[i]), .din(m_araddr[i*AW +: AW]),
      .pop(rq_pop[i]), .dout(rq_addr[i]), .not_empty(rq_ne[i]),
      .not_full(m_arready[i]));

    assign rq_tgt[i] = pick_target(rq_addr[i]);

    xbr_fifo #(.W(SIW), .DEPTH(RI_DEPTH)) u_route (
      .clk, .rst, .push(rq_pop[i]), .din(rq_tgt[i]),
      .pop(rsp_go[i]), .dout(ri_head[i]), .not_empty(ri_ne[i]),
      .not_full(ri_nf[i]));

    xbr_fifo #(.W(RW), .DEPTH(RQ_DEPTH)) u_rq (
      .clk, .rst, .push(rsp_go[i]), .din(rsp_din[i]),
      .pop(m_rready[i]), .dout(rd_dout), .not_empty(m_rvalid[i]),
      .not_full(rd_nf[i]));

    assign m_rdata[i*DW +: DW]  = rd_dout[DW-1:0];
    assign m_rresp[i*2 +: 2]    = rd_dout[RW-1 -: RESP_W];
  end

  for (genvar j = 0; j < NS; j++) begin : g_tgt
    xbr_prio #(.N(NM)) u_pick (.req(ar_req[j]), .gnt(ar_gnt[j]));

    xbr_fifo #(.W(AW), .DEPTH(RQ_DEPTH)) u_arq (
      .clk, .rst, .push(tg_push[j]), .din(tg_addr[j]),
      .pop(s_arready[j]), .dout(s_araddr[j*AW +: AW]),
      .not_empty(s_arvalid[j]), .not_full(tg_nf[j]));

    xbr_fifo #(.W(MIW), .DEPTH(RI_DEPTH)) u_owner (
      .clk, .rst, .push(tg_push[j]), .din(tg_src[j]),
      .pop(tg_done[j]), .dout(to_head[j]), .not_empty(to_ne[j]),
      .not_full(to_nf[j]));

    xbr_fifo #(.W(RW), .DEPTH(RQ_DEPTH)) u_rs (
      .clk, .rst, .push(s_rvalid[j]),
      .din({s_rresp[j*2 +: 2], s_rdata[j*DW +: DW]}),
      .pop(tg_done[j]), .dout(rs_dout[j]), .not_empty(rs_ne[j]),
      .not_full(s_rready[j]));
  end
endmodule

// File: rtl/xbr_rd_route_chk.sv
module xbr_rd_route_chk #(
  parameter int            NM       = 2,
  parameter int            NS       = 4,
  parameter int            AW       = 8,
  parameter int            DW       = 16,
  parameter int            SELW     = 3,
  parameter logic [NS-1:0] RD_EN    = '1,
  parameter int            RQ_DEPTH = 2,
  parameter int            RI_DEPTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NM-1:0]      m_arvalid,
  input logic [NM*AW-1:0]   m_araddr,
  input logic [NM-1:0]      m_arready,
  input logic [NM-1:0]      m_rvalid,
  input logic [NM*DW-1:0]   m_rdata,
  input logic [NM*2-1:0]    m_rresp,
  input logic [NM-1:0]      m_rready,
  input logic [NS-1:0]      s_arvalid,
  input logic [NS*AW-1:0]   s_araddr,
  input logic [NS-1:0]      s_arready,
  input logic [NS-1:0]      s_rvalid,
  input logic [NS*DW-1:0]   s_rdata,
  input logic [NS*2-1:0]    s_rresp,
  input logic [NS-1:0]      s_rready
);
  localparam int CAP = 2 * RQ_DEPTH + RI_DEPTH;
  localparam int OCW = $clog2(CAP + 2) + 1;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (m_arready == '1 && m_rvalid == '0 && s_arvalid == '0));

  a_r3_masked_target_quiet: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid & ~RD_EN) == '0);

  for (genvar j = 0; j < NS; j++) begin : g_tchk
    a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
      (s_arvalid[j] && !s_arready[j]) |=>
        (s_arvalid[j] && $stable(s_araddr[j*AW +: AW])));
  end

  for (genvar i = 0; i < NM; i++) begin : g_mchk
    logic [OCW-1:0] outst;
    always_ff @(posedge clk) begin
      if (rst) outst <= '0;
      else outst <= outst + OCW'(m_arvalid[i] && m_arready[i])
                          - OCW'(m_rvalid[i] && m_rready[i]);
    end

    a_r7_outstanding_cap: assert property (@(posedge clk) disable iff (rst)
      outst <= OCW'(CAP));

    a_r10_resp_held: assert property (@(posedge clk) disable iff (rst)
      (m_rvalid[i] && !m_rready[i]) |=>
        (m_rvalid[i] && $stable(m_rdata[i*DW +: DW]) &&
         $stable(m_rresp[i*2 +: 2])));
  end
endmodule

bind xbr_rd_route xbr_rd_route_chk #(
  .NM(NM), .NS(NS), .AW(AW), .DW(DW), .SELW(SELW), .RD_EN(RD_EN),
  .RQ_DEPTH(RQ_DEPTH), .RI_DEPTH(RI_DEPTH)
) i_chk (.*);

// File: tb/test_xbr_rd_route.sv
module test_xbr_rd_route;
  localparam int NM = 2;
  localparam int NS = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [NS-1:0] EN = 4'b1011;
  localparam int QD = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NM-1:0]    m_arvalid = '0;
  logic [NM*AW-1:0] m_araddr  = '0;
  logic [NM-1:0]    m_arready;
  logic [NM-1:0]    m_rvalid;
  logic [NM*DW-1:0] m_rdata;
  logic [NM*2-1:0]  m_rresp;
  logic [NM-1:0]    m_rready  = '0;
  logic [NS-1:0]    s_arvalid;
  logic [NS*AW-1:0] s_araddr;
  logic [NS-1:0]    s_arready = '0;
  logic [NS-1:0]    s_rvalid  = '0;
  logic [NS*DW-1:0] s_rdata   = '0;
  logic [NS*2-1:0]  s_rresp   = '0;
  logic [NS-1:0]    s_rready;

  xbr_rd_route #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .SELW(3), .RD_EN(EN),
                 .RQ_DEPTH(2), .RI_DEPTH(8)) i_xbr_rd_route (.*);

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // bench-side controls set by the scenario
  logic [NM-1:0] want_mrdy = '1;
  logic [NS-1:0] want_sardy = '1;
  logic [NS-1:0] resp_en = '1;

  logic [AW-1:0] mq [NM][QD];
  int mq_h [NM], mq_t [NM];
  logic [AW-1:0] sq [NS][QD];
  int sq_h [NS], sq_t [NS];

  // logs
  logic [AW-1:0] tlog [NS][QD];
  int tcyc [NS][QD], tn [NS];
  int scyc [NS][QD], sn [NS];
  logic [DW+1:0] rx [NM][QD];
  int rxcyc [NM][QD], rn [NM];
  int acyc [NM][QD], an [NM];
  bit saw_masked = 0;

  logic [NM-1:0] arrdy_seen = '0, rv_seen = '0;
  logic [DW+1:0] rd_seen [NM];
  logic [NS-1:0] sav_seen = '0, srr_seen = '0;
  logic [AW-1:0] sa_seen [NS];

  function automatic int tgt_of(input logic [AW-1:0] a);
    int s;
    s = int'(a[7:5]);
    if (s < NS - 1 && EN[s]) return s;
    return NS - 1;
  endfunction

  function automatic logic [DW+1:0] resp_of(input int j, input logic [AW-1:0] a);
    logic [1:0] rc;
    rc = (j == NS - 1) ? 2'b11 : 2'b00;
    return {rc, 4'(j), 4'hA, a};
  endfunction

  // all DUT inputs are driven here, at the falling edge
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NM; i++) begin
      if (m_arvalid[i] && arrdy_seen[i]) begin
        mq_h[i]++;
        acyc[i][an[i]] = cyc; an[i]++;
      end
      arrdy_seen[i] = m_arready[i];
      m_arvalid[i] = (mq_h[i] != mq_t[i]);
      m_araddr[i*AW +: AW] = mq[i][mq_h[i]];
      if (rv_seen[i] && m_rready[i]) begin
        rx[i][rn[i]] = rd_seen[i]; rxcyc[i][rn[i]] = cyc; rn[i]++;
      end
      rv_seen[i] = m_rvalid[i];
      rd_seen[i] = {m_rresp[i*2 +: 2], m_rdata[i*DW +: DW]};
      m_rready[i] = want_mrdy[i];
    end
    for (int j = 0; j < NS; j++) begin
      if (s_arvalid[j]) if (!EN[j]) saw_masked = 1;
      if (sav_seen[j] && s_arready[j]) begin
        sq[j][sq_t[j]] = sa_seen[j]; sq_t[j]++;
        tlog[j][tn[j]] = sa_seen[j]; tcyc[j][tn[j]] = cyc; tn[j]++;
      end
      sav_seen[j] = s_arvalid[j];
      sa_seen[j]  = s_araddr[j*AW +: AW];
      s_arready[j] = want_sardy[j];
      if (s_rvalid[j] && srr_seen[j]) begin
        sq_h[j]++;
        scyc[j][sn[j]] = cyc; sn[j]++;
      end
      srr_seen[j] = s_rready[j];
      s_rvalid[j] = resp_en[j] && (sq_h[j] != sq_t[j]);
      {s_rresp[j*2 +: 2], s_rdata[j*DW +: DW]} = resp_of(j, sq[j][sq_h[j]]);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input int m, input logic [AW-1:0] a);
    mq[m][mq_t[m]] = a;
    mq_t[m]++;
  endtask

  task automatic clr();
    for (int i = 0; i < NM; i++) begin rn[i] = 0; an[i] = 0; end
    for (int j = 0; j < NS; j++) begin tn[j] = 0; sn[j] = 0; end
  endtask

  initial begin
    for (int i = 0; i < NM; i++) begin mq_h[i] = 0; mq_t[i] = 0; end
    for (int j = 0; j < NS; j++) begin sq_h[j] = 0; sq_t[j] = 0; end
    clr();
    step(5);
    rst = 1'b0;
    // R1: reset state
    chk("R1 arready", 32'(m_arready), 32'h3);
    chk("R1 rvalid", 32'(m_rvalid), 32'h0);
    chk("R1 s_arvalid", 32'(s_arvalid), 32'h0);

    // R2/R4/R8: single read to target 0
    clr(); issue(0, 8'h05); step(12);
    chk("R2 t0 count", 32'(tn[0]), 1);
    chk("R2 t0 addr", 32'(tlog[0][0]), 32'h05);
    chk("R4 ar latency", 32'(tcyc[0][0] - acyc[0][0]), 2);
    chk("R4 r latency", 32'(rxcyc[0][0] - scyc[0][0]), 2);
    chk("R8 t0 data", 32'(rx[0][0]), 32'(resp_of(0, 8'h05)));

    // R2/R3: hole and masked target go to the error target
    clr(); issue(1, 8'h80); issue(1, 8'h45); step(16);
    chk("R2 err count", 32'(tn[NS-1]), 2);
    chk("R2 hole addr", 32'(tlog[NS-1][0]), 32'h80);
    chk("R3 masked addr", 32'(tlog[NS-1][1]), 32'h45);
    chk("R8 decerr 0", 32'(rx[1][0]), 32'(resp_of(3, 8'h80)));
    chk("R8 decerr 1", 32'(rx[1][1]), 32'(resp_of(3, 8'h45)));

    // R5: same-edge contention on target 1
    clr(); issue(0, 8'h21); issue(1, 8'h32); step(14);
    chk("R5 first", 32'(tlog[1][0]), 32'h21);
    chk("R5 second", 32'(tlog[1][1]), 32'h32);
    chk("R8 m0", 32'(rx[0][0]), 32'(resp_of(1, 8'h21)));
    chk("R8 m1", 32'(rx[1][0]), 32'(resp_of(1, 8'h32)));

    // R6: target not ready
    clr(); want_sardy[1] = 1'b0;
    issue(1, 8'h2a); issue(1, 8'h2b); issue(1, 8'h2c); step(10);
    chk("R6 valid held", 32'(s_arvalid[1]), 1);
    chk("R6 addr held", 32'(s_araddr[1*AW +: AW]), 32'h2a);
    chk("R6 none taken", 32'(tn[1]), 0);
    want_sardy[1] = 1'b1; step(16);
    chk("R6 count", 32'(tn[1]), 3);
    for (int k = 0; k < 3; k++) begin
      chk("R6 order", 32'(tlog[1][k]), 32'(8'h2a + k));
      chk("R8 data", 32'(rx[1][k]), 32'(resp_of(1, 8'(8'h2a + k))));
    end

    // R7: route-queue depth with responses withheld
    clr(); resp_en[0] = 1'b0;
    for (int k = 0; k < 12; k++) issue(0, 8'(k));
    step(40);
    chk("R7 target count", 32'(tn[0]), 8);
    chk("R7 accepted", 32'(an[0]), 10);
    chk("R7 arready low", 32'(m_arready[0]), 0);
    resp_en[0] = 1'b1; step(60);
    chk("R9 count", 32'(rn[0]), 12);
    for (int k = 0; k < 12; k++)
      chk("R9 in order", 32'(rx[0][k]), 32'(resp_of(0, 8'(k))));

    // R9: later target answers first
    clr(); resp_en[0] = 1'b0;
    issue(0, 8'h07); issue(0, 8'h27); step(16);
    chk("R9 fast target reached", 32'(tn[1]), 1);
    chk("R9 blocked", 32'(rn[0]), 0);
    resp_en[0] = 1'b1; step(16);
    chk("R9 first", 32'(rx[0][0]), 32'(resp_of(0, 8'h07)));
    chk("R9 second", 32'(rx[0][1]), 32'(resp_of(1, 8'h27)));

    // R10: requester stalls the response
    clr(); want_mrdy[1] = 1'b0; issue(1, 8'h11); step(12);
    chk("R10 valid", 32'(m_rvalid[1]), 1);
    chk("R10 data", 32'({m_rresp[3:2], m_rdata[31:16]}), 32'(resp_of(0, 8'h11)));
    step(5);
    chk("R10 still data", 32'({m_rresp[3:2], m_rdata[31:16]}), 32'(resp_of(0, 8'h11)));
    want_mrdy[1] = 1'b1; step(5);
    chk("R10 delivered", 32'(rn[1]), 1);
    chk("R10 once", 32'(m_rvalid[1]), 0);

    // R2/R8: full select sweep from both requesters at once
    clr();
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < NM; m++) issue(m, {3'(s), 5'(m * 3 + s)});
    step(60);
    for (int m = 0; m < NM; m++) begin
      chk("R8 sweep count", 32'(rn[m]), 8);
      for (int s = 0; s < 8; s++) begin
        logic [AW-1:0] a;
        a = {3'(s), 5'(m * 3 + s)};
        chk("R2 sweep", 32'(rx[m][s]), 32'(resp_of(tgt_of(a), a)));
      end
    end

    chk("R3 masked never valid", 32'(saw_masked), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule